// File: doc/BRIEF.md
# Background Debug Entry Controller

This block sits beside a processor core. It decides, for each debug-related event, whether the core stops in a background debug state or handles the event as an ordinary exception. When reset is released, the block samples an active-low breakpoint pin once. That sample sets a debug-enable state, which holds until the next reset.

After reset, four kinds of event are watched:

- a falling edge on the breakpoint pin;
- a decoded debug opcode;
- a decoded software-breakpoint opcode;
- a run of consecutive bus faults.

Each event is mapped, according to the enable state, to one of four outcomes: debug entry, a breakpoint exception with its vector, an illegal-instruction trap, or a permanent halt.

On debug entry the block raises `freeze` first. One cycle later it raises `cmdReady`, which enables the serial command port. It then waits for a one-cycle resume pulse. All outcome signals are registered, so they appear one clock after the event is evaluated.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: Debug mode is enabled when the synchronized `bkptN` is low on the last clock edge before `rstN` is released, and disabled when it is high. The state holds until the next reset, and it is resampled on every reset. While reset is low, all outputs are 0.
- R2: An external breakpoint event is a high-to-low transition of `bkptN` after a two-stage synchronizer. Holding `bkptN` low through reset release and then raising it produces no event. If `bkptN` falls before rising edge P1, the event is evaluated at rising edge P3.
- R3: For an external breakpoint event with debug enabled, `freeze` rises and `excReq` and `bkptAckReq` stay 0. With debug disabled, `excReq` and `bkptAckReq` pulse together for one cycle, with `excVector` = 0x0C.
- R4: `opValid` with `opcode` = 0x4AFA enters debug mode when debug is enabled. When debug is disabled, it gives a one-cycle `illegalTrap` pulse.
- R5: `opValid` with an opcode in 0x4848..0x484F gives a one-cycle `swBkptReq` pulse in either enable state. `freeze` never rises for it.
- R6: Two `busFault` strobes with no `busDone` strobe between them form a double fault. With debug enabled it enters debug mode. With debug disabled, `halted` rises and stays high until reset, and all later events are ignored.
- R7: A `busDone` strobe between two `busFault` strobes clears the fault count, so no outcome is produced.
- R8: `freeze` rises on the edge that samples the event. `cmdReady` rises one edge later. Both stay high until a `resumeCmd` pulse is sampled while `cmdReady` is high. Both then fall on that same edge, and the fault count is cleared.
- R9: While `freeze` is high, breakpoint edges, opcodes and bus faults produce no outcome.
- R10: When several events are evaluated in the same cycle, only one outcome is produced. The order of precedence is double fault, then external breakpoint, then opcode events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; its release latches the debug enable |
| bkptN | input | 1 | Active-low breakpoint pin, asynchronous |
| opValid | input | 1 | Strobe: `opcode` holds a decoded instruction |
| opcode | input | 16 | Decoded instruction word |
| busDone | input | 1 | Strobe: a bus cycle completed without error |
| busFault | input | 1 | Strobe: a bus cycle ended in a fault |
| resumeCmd | input | 1 | One-cycle resume command from the serial port |
| freeze | output | 1 | Core is held in background debug |
| cmdReady | output | 1 | Serial command port enabled, waiting for a command |
| excReq | output | 1 | One-cycle breakpoint exception request |
| excVector | output | 8 | Exception vector, valid while `excReq` is high |
| bkptAckReq | output | 1 | One-cycle request for a breakpoint-acknowledge bus cycle |
| illegalTrap | output | 1 | One-cycle illegal-instruction trap request |
| swBkptReq | output | 1 | One-cycle software-breakpoint (opcode substitution) request |
| halted | output | 1 | Core halted after a double fault; stays high until reset |

## Verification
Each event source is driven twice: once after a reset with the pin high and once after a reset with the pin low. This shows that the enable state alone decides between debug entry and the exception, trap or halt outcome. A final reset with the pin high again checks that the enable is resampled on every reset.

Fault sequences with and without an intervening completed bus cycle separate a real double fault from two unrelated faults. A single fault issued after a resume shows that the count was cleared.

Events are stacked into the same evaluation cycle: a pin edge together with the debug opcode, and a second fault together with the debug opcode. Only the higher-ranked outcome may appear.

Events are also issued while the core is frozen, and the pin is held low across reset release. Neither may produce any outcome.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

  // Events decoded by the datapath, before priority and enable are applied.
  typedef struct packed {
    logic dblFault;
    logic extBkpt;
    logic dbgOp;
    logic swOp;
  } evt_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic countFault;
    logic clearFault;
    logic loadVec;
  } ctl_t;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_FROZEN = 2'd1,
    ST_HALTED = 2'd2
  } state_t;

endpackage

// File: rtl/dbg_entry_dp.sv
module dbg_entry_dp
  import dbg_entry_pkg::*;
#(
  parameter int          OPW         = 16,
  parameter int          VECW        = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          FAULT_LIMIT = 2,
  parameter logic [15:0] DBG_OP      = 16'h4AFA,
  parameter logic [15:0] SWB_BASE    = 16'h4848,
  parameter logic [15:0] SWB_MASK    = 16'hFFF8,
  parameter logic [7:0]  BKPT_VEC    = 8'h0C
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bkptN,
  input  logic            opValid,
  input  logic [OPW-1:0]  opcode,
  input  logic            busDone,
  input  logic            busFault,
  input  ctl_t            ctl,
  output evt_t            evt,
  output logic            dbgEn,
  output logic [VECW-1:0] excVector
);

  localparam int CNTW = $clog2(FAULT_LIMIT + 1);
  localparam logic [CNTW-1:0] CNT_TOP = CNTW'(FAULT_LIMIT - 1);

  // Synchronizer for the asynchronous pin; runs through reset so the
  // enable can be sampled at reset release.
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinSync;
  logic                   pinPrev;

  always_ff @(posedge clk) begin
    syncQ   <= {syncQ[SYNC_STAGES-2:0], bkptN};
    pinPrev <= pinSync;
  end

  assign pinSync = syncQ[SYNC_STAGES-1];

  // Enable tracks the pin while reset is low and freezes at release.
  always_ff @(posedge clk) begin
    if (!rstN) dbgEn <= ~pinSync;
  end

  // Consecutive bus fault counter, saturating at FAULT_LIMIT-1.
  logic [CNTW-1:0] faultCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultCnt <= '0;
    end else if (ctl.clearFault) begin
      faultCnt <= '0;
    end else if (ctl.countFault) begin
      if (busFault) begin
        if (faultCnt != CNT_TOP) faultCnt <= faultCnt + 1'b1;
      end else if (busDone) begin
        faultCnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) excVector <= '0;
    else       excVector <= ctl.loadVec ? VECW'(BKPT_VEC) : '0;
  end

  always_comb begin
    evt.dblFault = busFault && (faultCnt == CNT_TOP);
    evt.extBkpt  = pinPrev && !pinSync;
    evt.dbgOp    = opValid && (opcode == OPW'(DBG_OP));
    evt.swOp     = opValid && ((opcode & OPW'(SWB_MASK)) == OPW'(SWB_BASE));
  end

  // R6: the counter never reaches the limit; the limiting fault is an event.
  assert_fault_count_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultCnt < CNTW'(FAULT_LIMIT));

  // R7: a completed bus cycle while counting clears the count.
  assert_done_clears_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countFault && !ctl.clearFault && busDone && !busFault) |=> faultCnt == '0);

  // R1: the enable does not change once reset has been released.
  assert_enable_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(dbgEn));

endmodule

// File: rtl/dbg_entry_ctl.sv
module dbg_entry_ctl
  import dbg_entry_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  evt_t evt,
  input  logic dbgEn,
  input  logic resumeCmd,
  output ctl_t ctl,
  output logic freeze,
  output logic cmdReady,
  output logic excReq,
  output logic bkptAckReq,
  output logic illegalTrap,
  output logic swBkptReq,
  output logic halted
);

  state_t state;
  logic   running;
  logic   enterDbg, goHalt, wantExc, wantIll, wantSwb, doResume;

  assign running  = (state == ST_RUN);
  assign doResume = (state == ST_FROZEN) && cmdReady && resumeCmd;

  // Fixed priority: double fault, external breakpoint, opcode events.
  always_comb begin
    enterDbg = 1'b0;
    goHalt   = 1'b0;
    wantExc  = 1'b0;
    wantIll  = 1'b0;
    wantSwb  = 1'b0;
    if (running) begin
      if (evt.dblFault) begin
        if (dbgEn) enterDbg = 1'b1;
        else       goHalt   = 1'b1;
      end else if (evt.extBkpt) begin
        if (dbgEn) enterDbg = 1'b1;
        else       wantExc  = 1'b1;
      end else if (evt.dbgOp) begin
        if (dbgEn) enterDbg = 1'b1;
        else       wantIll  = 1'b1;
      end else if (evt.swOp) begin
        wantSwb = 1'b1;
      end
    end
  end

  always_comb begin
    ctl.countFault = running;
    ctl.clearFault = doResume;
    ctl.loadVec    = wantExc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_RUN;
      cmdReady    <= 1'b0;
      excReq      <= 1'b0;
      bkptAckReq  <= 1'b0;
      illegalTrap <= 1'b0;
      swBkptReq   <= 1'b0;
    end else begin
      if (enterDbg)      state <= ST_FROZEN;
      else if (goHalt)   state <= ST_HALTED;
      else if (doResume) state <= ST_RUN;
      cmdReady    <= (state == ST_FROZEN) && !doResume;
      excReq      <= wantExc;
      bkptAckReq  <= wantExc;
      illegalTrap <= wantIll;
      swBkptReq   <= wantSwb;
    end
  end

  assign freeze = (state == ST_FROZEN);
  assign halted = (state == ST_HALTED);

  // R8: the command port is only ready while frozen, and only after freeze.
  assert_ready_inside_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> freeze);
  assert_ready_after_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdReady) |-> $past(freeze));

  // R3: the exception path carries the acknowledge cycle; debug entry does not.
  assert_exc_only_disabled_R3: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (bkptAckReq && !dbgEn && !freeze));
  assert_ack_with_exc_R3: assert property (@(posedge clk) disable iff (!rstN)
    bkptAckReq |-> excReq);

  // R4: the illegal trap for the debug opcode only arises when disabled.
  assert_trap_only_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    illegalTrap |-> !dbgEn);

  // R5: the software breakpoint never coincides with debug state.
  assert_swbkpt_no_freeze_R5: assert property (@(posedge clk) disable iff (!rstN)
    swBkptReq |-> !freeze);

  // R6: halt is permanent until reset.
  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R9: nothing escapes while frozen without a resume.
  assert_frozen_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && !(cmdReady && resumeCmd)) |=>
      (freeze && !excReq && !illegalTrap && !swBkptReq));

  // R10: at most one outcome per evaluation.
  assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({excReq, illegalTrap, swBkptReq, $rose(freeze), $rose(halted)}));

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int          OPW         = 16,
  parameter int          VECW        = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          FAULT_LIMIT = 2,
  parameter logic [15:0] DBG_OP      = 16'h4AFA,
  parameter logic [15:0] SWB_BASE    = 16'h4848,
  parameter logic [15:0] SWB_MASK    = 16'hFFF8,
  parameter logic [7:0]  BKPT_VEC    = 8'h0C
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bkptN,
  input  logic            opValid,
  input  logic [OPW-1:0]  opcode,
  input  logic            busDone,
  input  logic            busFault,
  input  logic            resumeCmd,
  output logic            freeze,
  output logic            cmdReady,
  output logic            excReq,
  output logic [VECW-1:0] excVector,
  output logic            bkptAckReq,
  output logic            illegalTrap,
  output logic            swBkptReq,
  output logic            halted
);

  evt_t evt;
  ctl_t ctl;
  logic dbgEn;

  dbg_entry_dp #(
    .OPW(OPW), .VECW(VECW), .SYNC_STAGES(SYNC_STAGES), .FAULT_LIMIT(FAULT_LIMIT),
    .DBG_OP(DBG_OP), .SWB_BASE(SWB_BASE), .SWB_MASK(SWB_MASK), .BKPT_VEC(BKPT_VEC)
  ) i_dp (
    .clk(clk), .rstN(rstN), .bkptN(bkptN), .opValid(opValid), .opcode(opcode),
    .busDone(busDone), .busFault(busFault), .ctl(ctl), .evt(evt),
    .dbgEn(dbgEn), .excVector(excVector)
  );

  dbg_entry_ctl i_ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .dbgEn(dbgEn), .resumeCmd(resumeCmd),
    .ctl(ctl), .freeze(freeze), .cmdReady(cmdReady), .excReq(excReq),
    .bkptAckReq(bkptAckReq), .illegalTrap(illegalTrap), .swBkptReq(swBkptReq),
    .halted(halted)
  );

endmodule

// File: tb/test_dbg_entry_ctrl.sv
module test_dbg_entry_ctrl;

  typedef enum int {K_EXC, K_ILL, K_SWB, K_FRZ, K_HLT} kind_t;
  typedef struct {
    kind_t kind;
    string req;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bkptN = 1'b1;
  logic        opValid = 1'b0;
  logic [15:0] opcode = 16'h0;
  logic        busDone = 1'b0;
  logic        busFault = 1'b0;
  logic        resumeCmd = 1'b0;
  logic        freeze, cmdReady, excReq, bkptAckReq, illegalTrap, swBkptReq, halted;
  logic [7:0]  excVector;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t sbq[$];

  always #4 clk = ~clk;  // 125 MHz

  dbg_entry_ctrl i_dbg_entry_ctrl (
    .clk(clk), .rstN(rstN), .bkptN(bkptN), .opValid(opValid), .opcode(opcode),
    .busDone(busDone), .busFault(busFault), .resumeCmd(resumeCmd),
    .freeze(freeze), .cmdReady(cmdReady), .excReq(excReq), .excVector(excVector),
    .bkptAckReq(bkptAckReq), .illegalTrap(illegalTrap), .swBkptReq(swBkptReq),
    .halted(halted)
  );

  function automatic string kname(kind_t k);
    case (k)
      K_EXC:   return "EXC";
      K_ILL:   return "ILL";
      K_SWB:   return "SWB";
      K_FRZ:   return "FRZ";
      default: return "HLT";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expectItem(kind_t k, string req);
    item_t it;
    it.kind = k;
    it.req  = req;
    sbq.push_back(it);
  endtask

  task automatic gotItem(kind_t k);
    item_t it;
    checks++;
    if (sbq.size() == 0) begin
      errors++;
      $display("FAIL unexpected outcome: actual=%s expected=none", kname(k));
    end else begin
      it = sbq.pop_front();
      if (it.kind != k) begin
        errors++;
        $display("FAIL %s outcome: actual=%s expected=%s", it.req, kname(k), kname(it.kind));
      end
    end
  endtask

  // Monitor: pops the scoreboard as outcomes appear, away from the clock edge.
  logic prevFreeze = 1'b0, prevHalted = 1'b0;
  int   frzAge = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevFreeze = 1'b0;
      prevHalted = 1'b0;
      frzAge     = 0;
    end else begin
      if (excReq) begin
        gotItem(K_EXC);
        check(excVector == 8'h0C, "R3", "excVector", excVector, 12);
        check(bkptAckReq == 1'b1, "R3", "bkptAckReq with excReq", bkptAckReq, 1);
      end
      if (illegalTrap) gotItem(K_ILL);
      if (swBkptReq)   gotItem(K_SWB);
      if (freeze && !prevFreeze) begin
        gotItem(K_FRZ);
        check(bkptAckReq == 1'b0 && cmdReady == 1'b0, "R3", "ack/ready at freeze rise",
              {bkptAckReq, cmdReady}, 0);
      end
      if (halted && !prevHalted) gotItem(K_HLT);
      if (frzAge == 1) check(cmdReady == 1'b1, "R8", "cmdReady one cycle after freeze", cmdReady, 1);
      frzAge     = freeze ? frzAge + 1 : 0;
      prevFreeze = freeze;
      prevHalted = halted;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drained(string req);
    cyc(3);
    check(sbq.size() == 0, req, "pending outcomes not seen", sbq.size(), 0);
    sbq.delete();
  endtask

  task automatic doReset(logic pin);
    bkptN = pin;
    rstN  = 1'b0;
    cyc(3);
    check({freeze, cmdReady, excReq, bkptAckReq, illegalTrap, swBkptReq, halted} == 7'b0 &&
          excVector == 8'h0, "R1", "outputs in reset",
          {freeze, cmdReady, excReq, bkptAckReq, illegalTrap, swBkptReq, halted}, 0);
    cyc(3);
    rstN = 1'b1;
    cyc(3);
  endtask

  task automatic sendOp(logic [15:0] op);
    opcode  = op;
    opValid = 1'b1;
    cyc(1);
    opValid = 1'b0;
    cyc(3);
  endtask

  task automatic pulseFault();
    busFault = 1'b1;
    cyc(1);
    busFault = 1'b0;
    cyc(2);
  endtask

  task automatic pulseDone();
    busDone = 1'b1;
    cyc(1);
    busDone = 1'b0;
    cyc(2);
  endtask

  task automatic pinPulse();
    bkptN = 1'b0;
    cyc(5);
    bkptN = 1'b1;
    cyc(4);
  endtask

  task automatic resume();
    cyc(2);
    check(freeze && cmdReady, "R8", "frozen and ready before resume", {freeze, cmdReady}, 3);
    resumeCmd = 1'b1;
    cyc(1);
    resumeCmd = 1'b0;
    check(!freeze && !cmdReady, "R8", "released after resume", {freeze, cmdReady}, 0);
    cyc(2);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // ---- Disabled: pin high at reset release (R1)
    doResume0: begin end
    doReset(1'b1);
    drained("R1");

    expectItem(K_ILL, "R4");            // debug opcode traps when disabled
    sendOp(16'h4AFA);
    expectItem(K_SWB, "R5");            // software breakpoint, disabled
    sendOp(16'h484B);
    expectItem(K_EXC, "R3");            // pin edge gives exception
    pinPulse();
    drained("R3");
    sendOp(16'h1234);                   // unrelated opcode: nothing
    drained("R4");

    pulseFault(); pulseDone(); pulseFault();   // R7: completed cycle between faults
    drained("R7");
    pulseDone();

    // R10 and R2: pin edge evaluated on the third edge, together with debug opcode
    expectItem(K_EXC, "R10");
    bkptN = 1'b0;
    cyc(2);
    opcode = 16'h4AFA; opValid = 1'b1;
    cyc(1);
    opValid = 1'b0;
    cyc(3);
    bkptN = 1'b1;
    drained("R10");

    // R6 and R10: double fault with debug opcode in the same cycle halts only
    pulseFault();
    expectItem(K_HLT, "R6");
    busFault = 1'b1; opcode = 16'h4AFA; opValid = 1'b1;
    cyc(1);
    busFault = 1'b0; opValid = 1'b0;
    cyc(2);
    drained("R6");
    sendOp(16'h4AFA); pinPulse(); sendOp(16'h484C);
    check(halted == 1'b1, "R6", "halted stays high", halted, 1);
    drained("R6");

    // ---- Enabled: pin held low through reset release
    doReset(1'b0);
    cyc(2);
    bkptN = 1'b1;                       // rising edge only: no event (R2)
    cyc(4);
    check(freeze == 1'b0, "R2", "no event from held pin", freeze, 0);
    drained("R2");

    expectItem(K_FRZ, "R3");
    pinPulse();
    // R9: events while frozen are ignored
    sendOp(16'h4AFA); sendOp(16'h4849); pinPulse(); pulseFault(); pulseFault();
    drained("R9");
    resume();

    expectItem(K_FRZ, "R4");
    sendOp(16'h4AFA);
    resume();

    expectItem(K_SWB, "R5");
    sendOp(16'h484F);
    check(freeze == 1'b0, "R5", "no freeze for software breakpoint", freeze, 0);
    drained("R5");

    expectItem(K_FRZ, "R6");            // double fault enters debug when enabled
    pulseFault(); pulseFault();
    resume();

    // R8: resume clears the fault count
    pulseFault();
    expectItem(K_FRZ, "R8");
    sendOp(16'h4AFA);
    resume();
    pulseFault();
    check(freeze == 1'b0, "R8", "single fault after resume", freeze, 0);
    drained("R8");
    pulseDone();

    // ---- Disabled again: enable resampled (R1)
    doReset(1'b1);
    expectItem(K_ILL, "R1");
    sendOp(16'h4AFA);
    drained("R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule